// File: doc/BRIEF.md
# Serial-Bus EEPROM Target with One-Way Lower-Half Lock

This block is an I2C target that behaves like a 256-byte serial EEPROM, the kind that holds configuration data on a plug-in memory module. A host addresses it with a seven-bit target address whose low three bits come from strap pins. It then sets a one-byte word pointer and streams data bytes in or out. The pointer steps after every byte and wraps from the top of the array back to zero.

A second target address sits 0x20 below the memory address. It exists only to set a write-protect latch. A write-direction access there is acknowledged, including a bare address with no data byte. A single data byte sent to it sets the latch. After that, the lower 128 bytes of the array keep their contents, and the companion address no longer answers.

SCL and SDA are sampled on the system clock. SDA is open drain: the block pulls the line low when `sda_oe` is 1 and otherwise leaves it released. Only the power-on reset clears the array, which comes up erased to 0xFF, and the latch.

Top module: `eep_wp_target`

## Requirements
- R1: The memory target acknowledges the 7-bit address {4'b1010, strap} in either direction. It leaves any other address that is not the armed companion address unacknowledged.
- R2: A write access stores its first byte as the word pointer. Each further byte is stored at the pointer, and every byte is acknowledged.
- R3: A read access returns the byte at the pointer, MSB first. A master ACK (SDA low) continues with the next byte, and a master NACK ends the transfer with SDA released.
- R4: The word pointer advances by one after each data byte read or written and wraps from 0xFF to 0x00. A current-address read continues from where the last access left off.
- R5: The companion target {4'b0110, strap} acknowledges write-direction addressing, so a quick write with no data is accepted. A quick write does not set the lock. It never acknowledges read-direction addressing.
- R6: A data byte written to the companion target is acknowledged and sets the lock.
- R7: While locked, writes to word addresses 0x00–0x7F are still acknowledged but leave the stored byte unchanged. Addresses 0x80–0xFF stay writable.
- R8: While locked, the companion address is not acknowledged in either direction.
- R9: Only `rst_n` clears the lock and returns every array byte to 0xFF. No sequence of starts, stops or data on the bus clears the lock.
- R10: SDA is released (`sda_oe` = 0) after reset and after every STOP condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low power-on reset; clears array to 0xFF and the lock |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap | input | 3 | Low three bits of both target addresses |

## Verification
The hardest state to reach is the boundary of a locked array. The bench has to first send a data byte to the companion address, then run a multi-byte write that starts at 0x7F so that a single burst crosses from protected to writable cells. Only a readback of both cells, compared against a model that tracks the lock, shows that the crossing is correct. The stimulus reaches this state in a directed sequence: quick write, lock, then a probe of the now-silent companion address. Random bursts at random pointers come before and after the lock, so that wraps and half-boundary crossings happen in both lock states. A final reset shows that the latch and the array are cleared only by `rst_n`.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } bus_st_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_WORD,
    PH_DATA,
    PH_PROT
  } rx_ph_t;

  typedef enum logic [2:0] {
    GO_WORD,
    GO_DATA,
    GO_PROT,
    GO_TX,
    GO_IDLE
  } after_ack_t;

  // Replace the low w bits of a 7-bit base address with the strap value
  function automatic logic [6:0] place_strap(input logic [6:0] base,
                                             input logic [6:0] low,
                                             input int unsigned w);
    logic [7:0] wide;
    logic [6:0] mask;
    wide = (8'd1 << w) - 8'd1;
    mask = wide[6:0];
    return (base & ~mask) | (low & mask);
  endfunction

endpackage

// File: rtl/i2c_line_sense.sv
module i2c_line_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_lvl
);

  logic [SYNC_STAGES-1:0] scl_sh;
  logic [SYNC_STAGES-1:0] sda_sh;
  logic                   scl_d;
  logic                   sda_d;
  logic                   scl_s;
  logic                   sda_s;

  // Lines idle high, so sync flops reset to 1 to avoid a false start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s     = scl_sh[SYNC_STAGES-1];
  assign sda_s     = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign sda_lvl   = sda_s;

endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          lock_set,
  output logic          locked
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  // One register per cell; power-on value is the erased pattern
  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cells[g] <= '1;
      end else if (wr_en && (wr_addr == AW'(g))) begin
        cells[g] <= wr_data;
      end
    end
  end

  assign rd_data = cells[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
    end else if (lock_set) begin
      locked <= 1'b1;
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R9

  AST_LOCKED_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked) |-> wr_addr[AW-1]); // R7

endmodule

// File: rtl/eep_bus_fsm.sv
module eep_bus_fsm
  import eep_pkg::*;
#(
  parameter int         AW          = 8,
  parameter int         STRAP_W     = 3,
  parameter logic [6:0] MEM_BASE    = 7'h50,
  parameter logic [6:0] PROT_OFFSET = 7'h20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic               sda_lvl,
  input  logic [STRAP_W-1:0] strap,
  input  logic               locked,
  input  logic [7:0]         rd_data,
  output logic [AW-1:0]      rd_addr,
  output logic               wr_en,
  output logic [AW-1:0]      wr_addr,
  output logic [7:0]         wr_data,
  output logic               lock_set,
  output logic               sda_drv
);

  localparam logic [6:0] PROT_BASE = MEM_BASE - PROT_OFFSET;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return p + {{(AW-1){1'b0}}, 1'b1};
  endfunction

  bus_st_t    st;
  rx_ph_t     ph;
  after_ack_t nxt;
  logic [7:0] shreg;
  logic [3:0] bitcnt;
  logic [AW-1:0] ptr;
  logic       mnack;

  logic [6:0] mem_sel;
  logic [6:0] prot_sel;
  logic [7:0] nb;
  logic       byte_done;
  logic       mem_hit;
  logic       prot_hit;
  logic       low_open;

  assign mem_sel   = place_strap(MEM_BASE, 7'(strap), STRAP_W);
  assign prot_sel  = place_strap(PROT_BASE, 7'(strap), STRAP_W);
  assign nb        = {shreg[6:0], sda_lvl};
  assign byte_done = (st == ST_RX) && scl_rise && (bitcnt == 4'd7);
  assign mem_hit   = (nb[7:1] == mem_sel);
  assign prot_hit  = (nb[7:1] == prot_sel) && !nb[0] && !locked;
  assign low_open  = ptr[AW-1] || !locked;
  assign rd_addr   = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ph       <= PH_ADDR;
      nxt      <= GO_IDLE;
      shreg    <= '0;
      bitcnt   <= '0;
      ptr      <= '0;
      mnack    <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      lock_set <= 1'b0;
      sda_drv  <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      lock_set <= 1'b0;
      if (stop_det) begin
        st      <= ST_IDLE;
        sda_drv <= 1'b0;
      end else if (start_det) begin
        st      <= ST_RX;
        ph      <= PH_ADDR;
        bitcnt  <= '0;
        sda_drv <= 1'b0;
      end else begin
        unique case (st)
          ST_IDLE: ;
          ST_RX: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= nb;
              bitcnt <= bitcnt + 4'd1;
            end
            if (byte_done) begin
              unique case (ph)
                PH_ADDR: begin
                  if (mem_hit)       nxt <= nb[0] ? GO_TX : GO_WORD;
                  else if (prot_hit) nxt <= GO_PROT;
                  else               st  <= ST_IDLE;
                end
                PH_WORD: begin
                  ptr <= nb[AW-1:0];
                  nxt <= GO_DATA;
                end
                PH_DATA: begin
                  wr_en   <= low_open;
                  wr_addr <= ptr;
                  wr_data <= nb;
                  ptr     <= step(ptr);
                  nxt     <= GO_DATA;
                end
                PH_PROT: begin
                  lock_set <= 1'b1;
                  nxt      <= GO_IDLE;
                end
                default: ;
              endcase
            end
            if (scl_fall && bitcnt == 4'd8) begin
              sda_drv <= 1'b1;
              st      <= ST_ACK;
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_drv <= 1'b0;
              bitcnt  <= '0;
              unique case (nxt)
                GO_WORD: begin st <= ST_RX; ph <= PH_WORD; end
                GO_DATA: begin st <= ST_RX; ph <= PH_DATA; end
                GO_PROT: begin st <= ST_RX; ph <= PH_PROT; end
                GO_TX: begin
                  st      <= ST_TX;
                  shreg   <= rd_data;
                  ptr     <= step(ptr);
                  sda_drv <= ~rd_data[7];
                end
                default: st <= ST_IDLE;
              endcase
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end
            if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_drv <= 1'b0;
                st      <= ST_MACK;
              end else begin
                shreg   <= {shreg[6:0], 1'b0};
                sda_drv <= ~shreg[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mnack <= sda_lvl;
            end
            if (scl_fall) begin
              if (mnack) begin
                st <= ST_IDLE;
              end else begin
                st      <= ST_TX;
                bitcnt  <= '0;
                shreg   <= rd_data;
                ptr     <= step(ptr);
                sda_drv <= ~rd_data[7];
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  AST_PTR_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ptr == step(wr_addr))); // R4

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_drv); // R10

  AST_PROT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACK && nxt == GO_PROT) |-> !locked); // R8

  AST_LOCK_FROM_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    lock_set |-> $past(ph == PH_PROT)); // R6

endmodule

// File: rtl/eep_wp_target.sv
module eep_wp_target #(
  parameter int         AW          = 8,
  parameter int         STRAP_W     = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] MEM_BASE    = 7'h50,
  parameter logic [6:0] PROT_OFFSET = 7'h20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap
);

  logic          scl_rise;
  logic          scl_fall;
  logic          start_det;
  logic          stop_det;
  logic          sda_lvl;
  logic          locked;
  logic          lock_set;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;

  i2c_line_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_lvl  (sda_lvl)
  );

  eep_bus_fsm #(
    .AW(AW), .STRAP_W(STRAP_W), .MEM_BASE(MEM_BASE), .PROT_OFFSET(PROT_OFFSET)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_lvl  (sda_lvl),
    .strap    (strap),
    .locked   (locked),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .lock_set (lock_set),
    .sda_drv  (sda_oe)
  );

  eep_store #(.AW(AW), .DW(8)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .lock_set(lock_set),
    .locked  (locked)
  );

endmodule

// File: tb/tb_eep_wp_target.sv
module tb_eep_wp_target;

  localparam int Q = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b010;
  wire        sda_oe;
  wire        bus_sda = sda_m & ~sda_oe;

  logic [7:0] ref_mem [256];
  bit         ref_lock;
  logic [7:0] ref_ptr;
  logic [7:0] wbuf [8];
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  eep_wp_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus_sda),
    .sda_oe(sda_oe), .strap(strap)
  );

  function automatic logic [6:0] mem_a7(input logic [2:0] s);
    return 7'h50 | {4'b0, s};
  endfunction
  function automatic logic [6:0] prot_a7(input logic [2:0] s);
    return 7'h30 | {4'b0, s};
  endfunction
  function automatic bit exp_addr_ack(input logic [6:0] a7, input bit rw);
    return (a7 == mem_a7(strap)) || (!rw && !ref_lock && a7 == prot_a7(strap));
  endfunction
  function automatic bit cell_frozen(input logic [7:0] a);
    return ref_lock && !a[7];
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic put_bit(input bit b);
    sda_m = b; qwait();
    scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    b = bus_sda; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic put_byte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic get_byte(input bit more, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(!more);
  endtask

  task automatic probe(input string req, input logic [6:0] a7, input bit rw);
    bit ack;
    bus_start();
    put_byte({a7, rw}, ack);
    chk(req, "address ack", int'(ack), int'(exp_addr_ack(a7, rw)));
    bus_stop();
    chk("R10", "sda released after stop", int'(sda_oe), 0);
  endtask

  task automatic write_seq(input logic [7:0] wa, input int n);
    bit ack;
    bus_start();
    put_byte({mem_a7(strap), 1'b0}, ack);
    chk("R1", "memory write address ack", int'(ack), 1);
    put_byte(wa, ack);
    chk("R2", "word address ack", int'(ack), 1);
    ref_ptr = wa;
    for (int i = 0; i < n; i++) begin
      put_byte(wbuf[i], ack);
      if (cell_frozen(ref_ptr)) chk("R7", "locked cell data ack", int'(ack), 1);
      else begin
        chk("R2", "data ack", int'(ack), 1);
        ref_mem[ref_ptr] = wbuf[i];
      end
      ref_ptr = ref_ptr + 8'd1;
    end
    bus_stop();
  endtask

  task automatic read_seq(input string req, input logic [7:0] wa, input int n);
    bit ack;
    logic [7:0] v;
    bus_start();
    put_byte({mem_a7(strap), 1'b0}, ack);
    put_byte(wa, ack);
    ref_ptr = wa;
    bus_start();
    put_byte({mem_a7(strap), 1'b1}, ack);
    chk("R1", "memory read address ack", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i != n - 1, v);
      chk(req, "read data", int'(v), int'(ref_mem[ref_ptr]));
      ref_ptr = ref_ptr + 8'd1;
    end
    chk("R3", "sda released after master nack", int'(sda_oe), 0);
    bus_stop();
  endtask

  task automatic lock_write();
    bit ack;
    bus_start();
    put_byte({prot_a7(strap), 1'b0}, ack);
    chk("R5", "companion address ack before lock", int'(ack), 1);
    put_byte(8'h5A, ack);
    chk("R6", "companion data ack", int'(ack), 1);
    ref_lock = 1'b1;
    bus_stop();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    scl_m = 1'b1;
    sda_m = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
    ref_lock = 1'b0;
    ref_ptr = 8'h00;
  endtask

  task automatic random_bursts(input int count);
    logic [7:0] wa;
    int n;
    for (int k = 0; k < count; k++) begin
      wa = 8'($urandom);
      n = 1 + int'($urandom % 4);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      write_seq(wa, n);
      read_seq(ref_lock ? "R7" : "R2", wa, n);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    bit ack;
    void'($urandom(32'h1C2E5EED));
    do_reset();
    chk("R10", "sda released after reset", int'(sda_oe), 0);

    // R1: strap-selected addressing
    probe("R1", mem_a7(strap), 1'b0);
    probe("R1", mem_a7(~strap), 1'b0);
    probe("R1", 7'h48, 1'b1);

    // R9: erased contents after reset
    read_seq("R9", 8'h00, 2);

    // R2/R3: directed burst and readback
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    write_seq(8'h10, 4);
    read_seq("R3", 8'h10, 4);

    // R4: wrap from 0xFF to 0x00, then a current-address read
    wbuf[0] = 8'hA0; wbuf[1] = 8'hA1; wbuf[2] = 8'hA2;
    write_seq(8'hFE, 3);
    read_seq("R4", 8'hFE, 3);
    bus_start();
    put_byte({mem_a7(strap), 1'b1}, ack);
    get_byte(1'b0, v);
    chk("R4", "current-address read", int'(v), int'(ref_mem[ref_ptr]));
    ref_ptr = ref_ptr + 8'd1;
    bus_stop();

    // R5: companion target refuses reads, accepts a quick write
    probe("R5", prot_a7(strap), 1'b1);
    probe("R5", prot_a7(strap), 1'b0);
    wbuf[0] = 8'h77;
    write_seq(8'h05, 1);
    read_seq("R5", 8'h05, 1);

    random_bursts(6);

    // R6: lock via data byte; R8: companion goes silent
    lock_write();
    probe("R8", prot_a7(strap), 1'b0);
    probe("R8", prot_a7(strap), 1'b1);

    // R7: burst across the protected/writable boundary
    wbuf[0] = 8'hC7; wbuf[1] = 8'hC8;
    write_seq(8'h7F, 2);
    read_seq("R7", 8'h7F, 2);
    wbuf[0] = 8'h00;
    write_seq(8'h10, 1);
    read_seq("R7", 8'h10, 1);

    random_bursts(6);

    // R9: bus traffic and a strap change do not clear the lock
    strap = 3'b101;
    probe("R9", prot_a7(strap), 1'b0);
    probe("R1", mem_a7(strap), 1'b1);
    wbuf[0] = 8'h3C;
    write_seq(8'h20, 1);
    read_seq("R9", 8'h20, 1);

    // R9: only reset clears the lock and the array
    do_reset();
    probe("R9", prot_a7(strap), 1'b0);
    read_seq("R9", 8'h10, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule